// File: doc/BRIEF.md
# Quarter-Rate Data Clock Generator with Word Capture

This block runs on the sample clock and divides it by four to make a data clock for a parallel input port. It drives that clock onto a pin and uses the same internal timing to latch an 18-bit word from the port. The word is latched once per data-clock period, on the pin's rising edge. A one-cycle strobe marks each newly latched word.

Two controls change the behaviour. The invert control flips the pin and moves the capture point to the other half of the period, so capture always coincides with a rising edge of the pin. The enable control gates only the pin, which then sits at 0. Internal capture keeps running whether the pin is enabled or not. Reset clears the divider phase, so the capture points fall at fixed cycle counts after reset is released.

Top module: `dclk_capture`

## Requirements
- R1: The divider counts edges after reset release, with phase p = n mod 4 after the n-th edge. With enable=1 and invert=0, `dclk_o` is 0 for p in {0,1} and 1 for p in {2,3}. This gives a 50% duty cycle, and the first rising edge comes at edge 2.
- R2: While `rst_ni` is low, `dclk_o`, `valid_o` and `word_o` are all 0.
- R3: With invert=0, the word on `par_data_i` is captured at every edge that makes p=2. It appears on `word_o` in the cycle that follows that edge.
- R4: `valid_o` is 1 for exactly the one cycle in which a newly captured word first appears on `word_o`, and 0 in every other cycle.
- R5: `word_o` holds its value between captures. Changes on `par_data_i` at non-capture edges have no effect on it.
- R6: With invert=1, `dclk_o` is the complement of the R1 level. Capture happens at every edge that makes p=0, which is where the inverted pin rises.
- R7: With enable=0, `dclk_o` is 0 whatever the invert setting, and capture timing and data are unchanged.
- R8: `en_i` and `inv_i` are sampled at each edge. Their values at edge n decide `dclk_o` and the capture decision for that edge, with no further delay.
- R9: All 18 bits are captured unchanged, bit i of `par_data_i` going to bit i of `word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| par_data_i | input | 18 | Parallel input word |
| inv_i | input | 1 | Invert pin polarity and capture half |
| en_i | input | 1 | Drive data clock onto pin |
| dclk_o | output | 1 | Data clock pin |
| word_o | output | 18 | Last captured word |
| valid_o | output | 1 | One-cycle new-word strobe |

## Verification
A capture and a change of the pin settings can fall on the same edge. An `en_i` or `inv_i` toggle landing exactly on a capture edge must both move the capture point and reshape the pin in the next cycle. The bench provokes this by holding each setting for a while and then toggling both controls at random on every cycle, while a fresh random word is presented every cycle. A behavioural model fed the same sampled inputs gives the expected pin level, strobe and word for each cycle. Any disagreement is tagged R8 when a control changed on that edge.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
  parameter int unsigned DEF_WORD_W = 18;
  parameter int unsigned DEF_DIV    = 4;

  function automatic int unsigned ph_width(input int unsigned div);
    return (div <= 2) ? 1 : $clog2(div);
  endfunction
endpackage

// File: rtl/dclk_phase_gen.sv
module dclk_phase_gen #(
  parameter int unsigned DIV  = dclk_pkg::DEF_DIV,
  parameter int unsigned PH_W = dclk_pkg::ph_width(DIV)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_q_o,
  output logic [PH_W-1:0] ph_d_o,
  output logic            lvl_d_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] HALF_PH = PH_W'(DIV / 2);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  // Upper half of the period is the high level.
  assign lvl_d_o = (ph_d >= HALF_PH);
  assign ph_q_o  = ph_q;
  assign ph_d_o  = ph_d;

  // R1
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == LAST_PH) |=> (ph_q == '0));
  // R1
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != LAST_PH) |=> (ph_q == $past(ph_q) + 1'b1));
endmodule

// File: rtl/dclk_pin_out.sv
module dclk_pin_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_d_i,
  input  logic en_i,
  input  logic inv_i,
  output logic pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= en_i & (lvl_d_i ^ inv_i);
  end

  assign pin_o = pin_q;

  // R7
  pin_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pin_o);
endmodule

// File: rtl/dclk_word_latch.sv
module dclk_word_latch #(
  parameter int unsigned WORD_W = dclk_pkg::DEF_WORD_W,
  parameter int unsigned DIV    = dclk_pkg::DEF_DIV,
  parameter int unsigned PH_W   = dclk_pkg::ph_width(DIV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PH_W-1:0]   ph_q_i,
  input  logic [PH_W-1:0]   ph_d_i,
  input  logic              inv_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam logic [PH_W-1:0] HALF_PH = PH_W'(DIV / 2);

  logic              cap;
  logic [WORD_W-1:0] word_q;
  logic              vld_q;

  // Capture on the edge where the (possibly inverted) pin rises.
  assign cap = inv_i ? (ph_d_i == '0) : (ph_d_i == HALF_PH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= cap;
      if (cap) word_q <= data_i;
    end
  end

  assign word_o  = word_q;
  assign valid_o = vld_q;

  // R4
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R5
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));
  // R3
  cap_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(inv_i)) |-> (ph_q_i == HALF_PH));
  // R6
  cap_phase_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(inv_i)) |-> (ph_q_i == '0));
endmodule

// File: rtl/dclk_capture.sv
module dclk_capture #(
  parameter int unsigned WORD_W = dclk_pkg::DEF_WORD_W,
  parameter int unsigned DIV    = dclk_pkg::DEF_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] par_data_i,
  input  logic              inv_i,
  input  logic              en_i,
  output logic              dclk_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int unsigned PH_W = dclk_pkg::ph_width(DIV);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            lvl_d;

  dclk_phase_gen #(.DIV(DIV), .PH_W(PH_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_q_o  (ph_q),
    .ph_d_o  (ph_d),
    .lvl_d_o (lvl_d)
  );

  dclk_pin_out u_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_d_i (lvl_d),
    .en_i    (en_i),
    .inv_i   (inv_i),
    .pin_o   (dclk_o)
  );

  dclk_word_latch #(.WORD_W(WORD_W), .DIV(DIV), .PH_W(PH_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ph_q_i  (ph_q),
    .ph_d_i  (ph_d),
    .inv_i   (inv_i),
    .data_i  (par_data_i),
    .word_o  (word_o),
    .valid_o (valid_o)
  );

  // R8: an enabled capture coincides with the pin's high level
  pin_at_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(en_i)) |-> dclk_o);
endmodule

// File: tb/tb_dclk_capture.sv
`timescale 1ns/1ps
module tb_dclk_capture;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] data = '0;
  logic         inv = 1'b0;
  logic         en = 1'b0;
  logic         dclk;
  logic [W-1:0] word;
  logic         valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dclk_capture dut (
    .clk_i(clk), .rst_ni(rst_n), .par_data_i(data), .inv_i(inv), .en_i(en),
    .dclk_o(dclk), .word_o(word), .valid_o(valid)
  );

  // Behavioural reference
  int           n_edges;
  logic         exp_pin, exp_vld;
  logic [W-1:0] exp_word = '0;
  logic         last_en, last_inv, ctl_changed;
  logic         cur_inv, cur_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_edges = 0; exp_pin = 0; exp_vld = 0; exp_word = '0;
      last_en = 0; last_inv = 0; ctl_changed = 0; cur_inv = 0; cur_en = 0;
    end else begin
      int p;
      n_edges = n_edges + 1;
      p = n_edges % 4;
      ctl_changed = (en !== last_en) || (inv !== last_inv);
      last_en = en; last_inv = inv; cur_inv = inv; cur_en = en;
      exp_pin = en & ((p >= 2) ^ inv);
      exp_vld = inv ? (p == 0) : (p == 2);
      if (exp_vld) exp_word = data;
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tp;
      tp = ctl_changed ? "R8" : (!cur_en ? "R7" : (cur_inv ? "R6" : "R1"));
      check({tp, " pin"}, W'(dclk), W'(exp_pin));
      check("R4 strobe", W'(valid), W'(exp_vld));
      if (exp_vld) check(cur_inv ? "R6 R9 word" : "R3 R9 word", word, exp_word);
      else         check("R5 word hold", word, exp_word);
    end
  end

  task automatic run(input int cycles, input int mode);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #0.5;
      case (mode)
        0: data = W'($urandom);
        1: data = W'(1) << (i % W);
        2: data = (i % 2) ? '1 : '0;
        default: begin
          data = W'($urandom);
          en = $urandom_range(0, 1);
          inv = $urandom_range(0, 1);
        end
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    checks++;
    if (dclk !== 0 || valid !== 0 || word !== '0) begin
      errors++;
      $display("FAIL R2: actual pin=%b vld=%b word=%h expected 0 0 0", dclk, valid, word);
    end
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    en = 1; inv = 0;
    run(40, 0);
    run(40, 1);
    en = 0;
    run(40, 0);
    en = 1; inv = 1;
    run(40, 2);
    en = 0;
    run(40, 0);
    run(400, 3);
    data = 18'h2AAAA; en = 1; inv = 0;
    do_reset();
    run(12, 1);
    inv = 1;
    do_reset();
    run(12, 0);
    run(300, 3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule